// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block sits behind clock recovery and line decoding on a synchronous serial receiver. It takes one data bit on each cycle in which `bit_en` is high. It looks for the flag octet, removes the zeros that the sender stuffed into the data, and packs the surviving payload bits into bytes. Bits arrive least significant first, and bytes are assembled least significant first. The address, control, information and frame check bits all reach the consumer as ordinary payload bytes. Address matching and CRC checking are left to downstream logic, which therefore still receives the final 16 bits before the closing flag.

Frame boundaries are reported as single-cycle pulses. `sof` pulses when a frame starts and `eof` pulses when it ends. When a frame's bit count is not a multiple of eight, the last byte is partial and `residue` gives its number of valid bits. One flag may close a frame and open the next at the same time. Two more line patterns are flagged on their own outputs:

- a run of seven or more ones, reported as an abort;
- seven ones followed by a zero, reported as end-of-poll.

A long run of ones is taken as an idle line.

All outputs are registered. Each one reflects the bit accepted on the previous clock edge.

Top module: `hdlc_deframer`

## Requirements
- R1: After synchronous reset every output is 0 and the block hunts for a flag. Until a flag (bits 0,1,1,1,1,1,1,0 in arrival order) has been received, it emits no byte, `sof` or `eof`.
- R2: The flag bits themselves never appear in the payload. The flag is matched on the raw line, without zero deletion.
- R3: Inside a frame, a 0 that follows exactly five consecutive 1s is discarded and is not counted as payload.
- R4: Payload bits are packed least-significant-bit first. `byte_valid` pulses with `byte_data` each time eight payload bits have been collected.
- R5: `sof` pulses exactly once per non-empty frame, before or with the frame's first `byte_valid`.
- R6: A closing flag after at least one payload bit pulses `eof` with `residue` set to (payload bits mod 8). When that value is nonzero, `byte_valid` pulses in the same cycle and `byte_data` holds the partial byte's valid bits right-aligned. `residue` is 0 in all other cycles.
- R7: A single flag between two frames ends the first frame and starts the second. Both frames are reported in full.
- R8: Adjacent flags with no payload bits between them produce no `sof`, `eof` or byte.
- R9: A seventh consecutive 1 received after a flag pulses `abort_p`. The open frame is dropped with no `eof`, and the block returns to hunting.
- R10: A 0 received immediately after exactly seven consecutive 1s pulses `eop_p`, in any state.
- R11: After 15 or more consecutive 1s (idle line) no frame is open. Nothing is emitted until the next flag.
- R12: A cycle with `bit_en` low changes no state, and in the following cycle all output strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received serial bit |
| byte_valid | output | 1 | `byte_data` holds a payload byte |
| byte_data | output | 8 | Payload byte, LSB received first; partial bytes right-aligned |
| sof | output | 1 | Frame start pulse |
| eof | output | 1 | Frame end pulse |
| residue | output | 3 | Valid bits in the final partial byte; only nonzero with `eof` |
| abort_p | output | 1 | Abort pulse |
| eop_p | output | 1 | End-of-poll pulse |

## Verification
A delay line left holding stale bits after a flag or abort would put flag bits or leftovers into the next frame. That shows as a wrong first byte or a wrong `residue` one frame later. A wrong run counter shows within one octet: a missed stuffed-zero deletion shifts every later byte of the frame, and a missed flag loses an `eof`. A packer fill count that survives a frame boundary misaligns every byte of the following frame. For that reason frames are sent back to back, across aborts and after idle runs, and not only one at a time from reset.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned FILL_W    = $clog2(BYTE_BITS);
  localparam int unsigned FLAG_LEN  = 8;
  // raw bits of a flag that are accepted as data before the flag is recognised
  localparam int unsigned LOOK_BACK = FLAG_LEN - 1;
  localparam int unsigned RUN_W     = 4;
  localparam int unsigned STUFF_RUN = 5;
  localparam int unsigned FLAG_RUN  = 6;
  localparam int unsigned EOP_RUN   = 7;
  localparam int unsigned IDLE_RUN  = 15;

  typedef enum logic {ST_HUNT, ST_OPEN} rx_state_e;

  // saturating count of consecutive ones
  function automatic logic [RUN_W-1:0] run_next(input logic [RUN_W-1:0] run,
                                                input logic            b);
    if (!b)                              return '0;
    else if (run == RUN_W'(IDLE_RUN))    return run;
    else                                 return run + RUN_W'(1);
  endfunction

  // partial byte: the n valid bits sit at the top of acc, move them to bit 0
  function automatic logic [BYTE_BITS-1:0] align_partial(input logic [BYTE_BITS-1:0] acc,
                                                         input logic [FILL_W-1:0]    n);
    logic [FILL_W:0] sh;
    sh = (FILL_W+1)'(BYTE_BITS) - {1'b0, n};
    return acc >> sh;
  endfunction

endpackage

// File: rtl/hdlc_run_tracker.sv
module hdlc_run_tracker
  import hdlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic ev_flag,
  output logic ev_stuff,
  output logic ev_seventh,
  output logic ev_eop,
  output logic idle
);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (bit_en) run_q <= run_next(run_q, bit_in);
  end

  assign ev_flag    = bit_en && !bit_in && (run_q == RUN_W'(FLAG_RUN));
  assign ev_stuff   = bit_en && !bit_in && (run_q == RUN_W'(STUFF_RUN));
  assign ev_eop     = bit_en && !bit_in && (run_q == RUN_W'(EOP_RUN));
  assign ev_seventh = bit_en &&  bit_in && (run_q == RUN_W'(FLAG_RUN));
  assign idle       = (run_q == RUN_W'(IDLE_RUN));

endmodule

// File: rtl/hdlc_look_back.sv
module hdlc_look_back
  import hdlc_pkg::*;
#(
  parameter int unsigned DEPTH = LOOK_BACK
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic push,
  input  logic din,
  output logic pop_valid,
  output logic pop_bit
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] pend_q;
  logic [CW-1:0]    cnt_q;
  logic             full_w;

  assign full_w    = (cnt_q == CW'(DEPTH));
  assign pop_valid = push && full_w;
  assign pop_bit   = pend_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (push) begin
      pend_q <= {pend_q[DEPTH-2:0], din};
      if (!full_w) cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/hdlc_bit_packer.sv
module hdlc_bit_packer
  import hdlc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 din,
  output logic                 full_valid,
  output logic [BYTE_BITS-1:0] full_word,
  output logic [FILL_W-1:0]    fill,
  output logic [BYTE_BITS-1:0] partial_word
);

  logic [BYTE_BITS-1:0] acc_q;
  logic [FILL_W-1:0]    fill_q;

  assign full_word    = {din, acc_q[BYTE_BITS-1:1]};
  assign full_valid   = shift_en && (fill_q == FILL_W'(BYTE_BITS - 1));
  assign fill         = fill_q;
  assign partial_word = align_partial(acc_q, fill_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      acc_q  <= full_word;
      fill_q <= fill_q + FILL_W'(1);
    end
  end

endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 bit_in,
  output logic                 byte_valid,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 sof,
  output logic                 eof,
  output logic [FILL_W-1:0]    residue,
  output logic                 abort_p,
  output logic                 eop_p
);

  rx_state_e state_q;
  logic      active_q;

  logic ev_flag, ev_stuff, ev_seventh, ev_eop, idle_w;
  logic hunting_w, push_w, clear_w, close_w, part_w;
  logic pop_v, pop_b;
  logic full_v;
  logic [BYTE_BITS-1:0] full_word, part_word;
  logic [FILL_W-1:0]    fill_w;

  hdlc_run_tracker u_run (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .ev_flag(ev_flag), .ev_stuff(ev_stuff), .ev_seventh(ev_seventh),
    .ev_eop(ev_eop), .idle(idle_w)
  );

  assign hunting_w = (state_q == ST_HUNT);
  assign push_w    = !hunting_w && bit_en && !ev_flag && !ev_stuff && !ev_seventh;
  assign clear_w   = ev_flag || ev_seventh;
  assign close_w   = ev_flag && !hunting_w && active_q;
  assign part_w    = close_w && (fill_w != '0);

  hdlc_look_back #(.DEPTH(LOOK_BACK)) u_lb (
    .clk(clk), .rst(rst), .clear(clear_w), .push(push_w), .din(bit_in),
    .pop_valid(pop_v), .pop_bit(pop_b)
  );

  hdlc_bit_packer u_pk (
    .clk(clk), .rst(rst), .clear(clear_w), .shift_en(pop_v), .din(pop_b),
    .full_valid(full_v), .full_word(full_word), .fill(fill_w),
    .partial_word(part_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HUNT;
      active_q <= 1'b0;
    end else if (ev_flag) begin
      state_q  <= ST_OPEN;
      active_q <= 1'b0;
    end else if (ev_seventh) begin
      state_q  <= ST_HUNT;
      active_q <= 1'b0;
    end else if (pop_v) begin
      active_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      sof        <= 1'b0;
      eof        <= 1'b0;
      residue    <= '0;
      abort_p    <= 1'b0;
      eop_p      <= 1'b0;
    end else begin
      byte_valid <= full_v || part_w;
      byte_data  <= full_v ? full_word : (part_w ? part_word : '0);
      sof        <= pop_v && !active_q;
      eof        <= close_w;
      residue    <= close_w ? fill_w : '0;
      abort_p    <= ev_seventh && !hunting_w;
      eop_p      <= ev_eop;
    end
  end

endmodule

// File: rtl/hdlc_deframer_chk.sv
module hdlc_deframer_chk
  import hdlc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              byte_valid,
  input logic              sof,
  input logic              eof,
  input logic [FILL_W-1:0] residue,
  input logic              abort_p,
  input logic              eop_p,
  input logic              hunting,
  input logic              idle,
  input logic              flag_evt
);

  // R1: while hunting, a non-flag bit yields no payload output
  assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (hunting && bit_en && !flag_evt) |=> (!byte_valid && !sof && !eof));

  // R6: a nonzero residue only appears alongside eof and the partial byte
  assert_residue_with_eof_R6: assert property (@(posedge clk) disable iff (rst)
    (residue != '0) |-> (eof && byte_valid));

  // R9: an abort never comes with a byte or a frame end
  assert_abort_no_eof_R9: assert property (@(posedge clk) disable iff (rst)
    abort_p |-> (!eof && !byte_valid));

  // R5: frame markers are mutually exclusive
  assert_marker_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sof, eof, abort_p}));

  // R11: an idle line never leaves a frame open
  assert_idle_hunts_R11: assert property (@(posedge clk) disable iff (rst)
    idle |-> hunting);

  // R10: end-of-poll is a line event, never coincident with payload
  assert_eop_no_data_R10: assert property (@(posedge clk) disable iff (rst)
    eop_p |-> (!byte_valid && !sof));

  // R12: no qualified bit, no strobe next cycle
  assert_gap_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!byte_valid && !sof && !eof && !abort_p && !eop_p));

endmodule

bind hdlc_deframer hdlc_deframer_chk chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .byte_valid(byte_valid),
  .sof(sof), .eof(eof), .residue(residue), .abort_p(abort_p), .eop_p(eop_p),
  .hunting(hunting_w), .idle(idle_w), .flag_evt(ev_flag)
);

// File: tb/hdlc_deframer_tb.sv
module hdlc_deframer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       byte_valid, sof, eof, abort_p, eop_p;
  logic [7:0] byte_data;
  logic [2:0] residue;

  int checks = 0;
  int errors = 0;
  bit gap_mode = 1'b0;
  int tx_ones = 0;

  // event log filled by the monitor
  logic [7:0] got [0:63];
  logic [2:0] eres [0:7];
  int nb, sof_n, eof_n, ab_n, eop_n, sof_late;

  always #2 clk = ~clk;

  hdlc_deframer dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .sof(sof), .eof(eof),
    .residue(residue), .abort_p(abort_p), .eop_p(eop_p)
  );

  // vectors: {payload bit count, payload (first bit in bit 0)}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {8'd16, 32'h0000_FFFF},
    {8'd8,  32'h0000_007E},
    {8'd13, 32'h0000_1A5B},
    {8'd24, 32'h00C3_7E81},
    {8'd1,  32'h0000_0001},
    {8'd31, 32'h5F3E_7BFF}
  };

  task automatic clr_log();
    nb = 0; sof_n = 0; eof_n = 0; ab_n = 0; eop_n = 0; sof_late = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (sof) begin
        sof_n++;
        if (nb != 0 && sof_n == 1) sof_late++;
      end
      if (byte_valid && nb < 64) begin got[nb] = byte_data; nb++; end
      if (eof) begin if (eof_n < 8) eres[eof_n] = residue; eof_n++; end
      if (abort_p) ab_n++;
      if (eop_p) eop_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic raw_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    if (gap_mode) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_flag();
    raw_bit(1'b0);
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_payload(input int n, input logic [31:0] d);
    tx_ones = 0;
    for (int i = 0; i < n; i++) begin
      raw_bit(d[i]);
      if (d[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin raw_bit(1'b0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  task automatic do_reset();
    bit_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, then hunting ignores non-flag data
    do_reset();
    chk({byte_valid, sof, eof, abort_p, eop_p, residue, byte_data} == '0,
        "R1 reset outputs", int'(byte_valid), 0);
    clr_log();
    for (int i = 0; i < 32; i++) raw_bit(i[0]);
    quiet(3);
    chk(nb == 0 && sof_n == 0 && eof_n == 0, "R1 hunt silent", nb, 0);

    // R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      int n, nfull, rem;
      logic [31:0] d;
      n = int'(VEC[v][39:32]);
      d = VEC[v][31:0];
      nfull = n / 8;
      rem = n % 8;
      clr_log();
      send_flag();
      send_payload(n, d);
      send_flag();
      quiet(3);
      chk(sof_n == 1 && sof_late == 0, "R5 sof once, before bytes", sof_n, 1);
      chk(eof_n == 1, "R6 eof once", eof_n, 1);
      chk(nb == nfull + (rem != 0 ? 1 : 0), "R2 byte count", nb, nfull + (rem != 0 ? 1 : 0));
      for (int k = 0; k < nfull && k < nb; k++)
        chk(got[k] == d[8*k +: 8], "R4 R3 byte value", int'(got[k]), int'(d[8*k +: 8]));
      if (rem != 0 && nb > nfull) begin
        logic [7:0] pe;
        pe = 8'((d >> (8*nfull)) & ((32'd1 << rem) - 1));
        chk(got[nfull] == pe, "R6 partial byte", int'(got[nfull]), int'(pe));
      end
      if (eof_n > 0) chk(int'(eres[0]) == rem, "R6 residue", int'(eres[0]), rem);
    end

    // R7 and R12: back-to-back frames sharing one flag, bit_en gaps
    gap_mode = 1'b1;
    clr_log();
    send_flag();
    send_payload(16, 32'h0000_BEEF);
    send_flag();
    send_payload(12, 32'h0000_00A5);
    send_flag();
    quiet(3);
    gap_mode = 1'b0;
    chk(sof_n == 2 && eof_n == 2, "R7 two frames", eof_n, 2);
    chk(nb == 4, "R12 gapped byte count", nb, 4);
    chk(got[0] == 8'hEF && got[1] == 8'hBE, "R7 first frame", int'(got[0]), 'hEF);
    chk(got[2] == 8'hA5 && got[3] == 8'h00, "R7 second frame", int'(got[2]), 'hA5);
    chk(eres[0] == 3'd0 && eres[1] == 3'd4, "R6 residues", int'(eres[1]), 4);

    // R8: adjacent flags only
    clr_log();
    send_flag(); send_flag(); send_flag();
    quiet(3);
    chk(sof_n == 0 && eof_n == 0 && nb == 0, "R8 empty frames silent", sof_n, 0);

    // R9: abort drops the frame
    clr_log();
    send_flag();
    send_payload(12, 32'h0000_00F0);
    for (int i = 0; i < 10; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    quiet(3);
    chk(ab_n == 1, "R9 abort pulse", ab_n, 1);
    chk(eof_n == 0, "R9 no eof", eof_n, 0);
    chk(nb == 1 && got[0] == 8'hF0, "R9 bytes before abort", nb, 1);
    chk(eop_n == 0, "R10 no eop after long run", eop_n, 0);
    // recovery after abort: the next frame is clean
    clr_log();
    send_flag();
    send_payload(8, 32'h0000_0055);
    send_flag();
    quiet(3);
    chk(nb == 1 && got[0] == 8'h55 && eof_n == 1, "R9 recovery", int'(got[0]), 'h55);

    // R10: end-of-poll while hunting
    do_reset();
    clr_log();
    raw_bit(1'b0);
    for (int i = 0; i < 7; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    quiet(3);
    chk(eop_n == 1, "R10 eop pulse", eop_n, 1);
    chk(ab_n == 0 && sof_n == 0, "R10 no abort in hunt", ab_n, 0);

    // R11: idle line closes the frame; nothing until the next flag
    clr_log();
    send_flag();
    for (int i = 0; i < 16; i++) raw_bit(1'b1);
    for (int i = 0; i < 16; i++) raw_bit(i[0]);
    quiet(3);
    chk(nb == 0 && sof_n == 0, "R11 idle silent", nb, 0);
    chk(ab_n == 1, "R11 abort on idle entry", ab_n, 1);
    send_flag();
    send_payload(8, 32'h0000_003C);
    send_flag();
    quiet(3);
    chk(nb == 1 && got[0] == 8'h3C && eof_n == 1, "R11 frame after idle", int'(got[0]), 'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule